// File: doc/BRIEF.md
# Misaligned Access Splitter

The block sits between a processor's data-access port and a narrower memory or peripheral bus. It takes one request of byte, halfword or word size at any byte address and runs it as a series of bus cycles of one or two bytes each. The address rises by one or two bytes after each cycle. For a write it places the right bytes of the request on the bus lanes. For a read it gathers the returned bytes into one 32-bit result with little-endian byte order.

Each request selects its own bus. The peripheral target is always 16 bits wide. The external target is 16 or 8 bits wide, chosen by a configuration input. Every bus cycle is held until the target signals ready. After the last cycle the block raises a single-cycle completion pulse.

Top module: `access_splitter`

## Requirements
- R1: A request is taken when `req_valid` is high and `busy` is low. `busy` rises in the next cycle and stays high until the last bus cycle is acknowledged. Requests presented while `busy` is high are ignored.
- R2: On the 8-bit external bus (`req_periph`=0, `cfg_ext8`=1) every cycle carries one byte: 1, 2 or 4 cycles for sizes 00, 01 and 10, at ascending consecutive addresses. `bus_be` is 01 and the byte travels on bits 7:0.
- R3: On a 16-bit bus, an aligned byte or halfword takes one cycle. A word at an address with low bits 00 takes two halfword cycles, at A and then A+2.
- R4: On a 16-bit bus, a halfword at an odd address takes two byte cycles, at A and then A+1.
- R5: On a 16-bit bus, a word at an odd address takes a byte cycle at A, then a halfword cycle at A+1, then a byte cycle at A+3.
- R6: On a 16-bit bus, a word at an address with low bits 10 takes two halfword cycles, at A and then A+2.
- R7: On a 16-bit bus, `bus_be` is 11 for a halfword cycle. For a byte cycle it is 01 when address bit 0 is 0 and 10 when it is 1, and the write byte is copied onto both halves of `bus_wdata`.
- R8: Write steering is little-endian. Request byte k (bits 8k+7:8k of `req_wdata`) is written to address A+k.
- R9: Read merging is little-endian. Byte k of `rdata` is the byte read from address A+k, and bytes beyond the request size read as zero.
- R10: While `bus_ready` is low, the current cycle's address, enables and write data stay unchanged.
- R11: `done` is high for exactly one cycle, the cycle after the last acknowledged bus cycle. `rdata` is valid from that cycle until the next request is taken.
- R12: A peripheral request (`req_periph`=1) uses the 16-bit sequencing whatever the value of `cfg_ext8`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word |
| req_addr | input | ADDR_W | Byte address of the first byte |
| req_wdata | input | 32 | Write data, byte k for address A+k |
| req_periph | input | 1 | 1 = peripheral target (16-bit) |
| cfg_ext8 | input | 1 | External bus width: 1 = 8 bits, 0 = 16 bits |
| busy | output | 1 | Access in progress |
| bus_valid | output | 1 | Bus cycle active |
| bus_write | output | 1 | Bus cycle direction |
| bus_addr | output | ADDR_W | Byte address of the bus cycle |
| bus_be | output | 2 | Lane enables, bit 0 = bits 7:0 |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data |
| bus_ready | input | 1 | Ends the current bus cycle |
| done | output | 1 | Completion pulse |
| rdata | output | 32 | Assembled read result |

## Verification
The bench sweeps every size over all four address phases on each of the three bus choices, for both reads and writes, with and without random ready stalls. It compares the logged cycle list and the memory image or read result against values worked out arithmetically. Some errors would show up in each comparison. A design that splits an odd-address word into two halfwords or four bytes would issue a misaligned halfword or the wrong number of cycles. One that picks the wrong lane would write the odd byte into the even location, or return bits 7:0 where bits 15:8 were needed. Leaving stale upper bytes in `rdata`, moving on during a stall, or accepting a request while busy would corrupt the memory image or the result.

// File: rtl/access_splitter.sv
module access_splitter #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              req_periph,
  input  logic              cfg_ext8,
  output logic              busy,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_be,
  output logic [15:0]       bus_wdata,
  input  logic [15:0]       bus_rdata,
  input  logic              bus_ready,
  output logic              done,
  output logic [31:0]       rdata
);

  logic              busy_q, wr_q, narrow_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        rem_q;
  logic [1:0]        off_q;
  logic [31:0]       wd_q, rd_q;

  wire        single = narrow_q | addr_q[0] | (rem_q == 3'd1);
  wire [2:0]  step   = single ? 3'd1 : 3'd2;
  wire [4:0]  sh     = {off_q, 3'b000};
  wire [31:0] wd_sh  = wd_q >> sh;
  wire [7:0]  rd_lo  = (!narrow_q && addr_q[0]) ? bus_rdata[15:8] : bus_rdata[7:0];
  wire [31:0] rd_ins = {16'h0, bus_rdata[15:8], rd_lo} << sh;
  wire [31:0] rd_msk = (single ? 32'h0000_00FF : 32'h0000_FFFF) << sh;
  wire        fire   = busy_q & bus_ready;

  assign busy      = busy_q;
  assign bus_valid = busy_q;
  assign bus_write = wr_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = single ? {wd_sh[7:0], wd_sh[7:0]} : wd_sh[15:0];
  assign bus_be    = narrow_q ? 2'b01 : (!single ? 2'b11 : (addr_q[0] ? 2'b10 : 2'b01));
  assign done      = done_q;
  assign rdata     = rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      wr_q     <= 1'b0;
      narrow_q <= 1'b0;
      done_q   <= 1'b0;
      addr_q   <= '0;
      rem_q    <= 3'd0;
      off_q    <= 2'd0;
      wd_q     <= 32'h0;
      rd_q     <= 32'h0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && req_valid) begin
        busy_q   <= 1'b1;
        wr_q     <= req_write;
        narrow_q <= !req_periph && cfg_ext8;
        addr_q   <= req_addr;
        off_q    <= 2'd0;
        wd_q     <= req_wdata;
        rd_q     <= 32'h0;
        case (req_size)
          2'b00:   rem_q <= 3'd1;
          2'b01:   rem_q <= 3'd2;
          default: rem_q <= 3'd4;
        endcase
      end else if (fire) begin
        if (!wr_q) rd_q <= (rd_q & ~rd_msk) | (rd_ins & rd_msk);
        addr_q <= addr_q + ADDR_W'(step);
        off_q  <= off_q + step[1:0];
        rem_q  <= rem_q - step;
        if (rem_q == step) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  a_r1_take: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && req_valid |=> busy_q);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !bus_ready |=> busy_q && $stable(bus_addr) && $stable(bus_be) && $stable(bus_wdata));
  a_r4_half_even: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && bus_be == 2'b11 |-> !bus_addr[0]);
  a_r2_narrow_lane: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !req_periph && cfg_ext8 && narrow_q |-> bus_be == 2'b01);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r11_done_after: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(busy_q && bus_ready) && !busy_q);

endmodule

// File: tb/access_splitter_tb_top.sv
module access_splitter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0, req_periph = 0, cfg_ext8 = 0;
  logic [1:0]  req_size = 0;
  logic [15:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic        busy, bus_valid, bus_write, done;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_be;
  logic        bus_ready = 0;
  logic [31:0] rdata;

  int checks = 0, fails = 0, wd_cnt = 0;
  logic [7:0] mem [0:63];
  logic [7:0] shadow [0:63];
  logic [15:0] log_addr [0:7];
  logic [1:0]  log_be [0:7];
  int log_n = 0;
  bit rep_ok = 1, narrow_bus = 0, stall_en = 0, force_stall = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  access_splitter #(.ADDR_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_periph(req_periph), .cfg_ext8(cfg_ext8), .busy(busy),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .done(done), .rdata(rdata));

  wire [5:0] ma = bus_addr[5:0];
  assign bus_rdata = narrow_bus ? {8'hEE, mem[ma]} : {mem[ma | 6'd1], mem[ma & 6'h3E]};

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    bus_ready = force_stall ? 1'b0 : (stall_en ? lfsr[0] : 1'b1);
  end

  always @(posedge clk) begin
    if (bus_valid && bus_ready) begin
      if (log_n < 8) begin
        log_addr[log_n] = bus_addr;
        log_be[log_n] = bus_be;
      end
      log_n++;
      if (bus_write) begin
        if (bus_be != 2'b11 && bus_wdata[15:8] != bus_wdata[7:0]) rep_ok = 0;
        if (narrow_bus) mem[ma] = bus_wdata[7:0];
        else begin
          if (bus_be[0]) mem[ma & 6'h3E] = bus_wdata[7:0];
          if (bus_be[1]) mem[ma | 6'd1] = bus_wdata[15:8];
        end
      end
    end
  end

  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 150000) begin
      fails++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 200) begin @(negedge clk); t++; end
  endtask

  task automatic access(input bit wr, input logic [1:0] sz, input logic [7:0] a, input int mode, input logic [31:0] wd);
    int nb, n, ea, w;
    bit seq_ok;
    string tag;
    logic [31:0] exp_rd;
    narrow_bus = (mode == 2);
    for (int i = 0; i < 64; i++) shadow[i] = mem[i];
    log_n = 0; rep_ok = 1;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_size = sz; req_addr = {8'h00, a};
    req_wdata = wd; req_periph = (mode == 0); cfg_ext8 = (mode != 1);
    @(negedge clk);
    req_valid = 0;
    wait_done();
    check(done === 1'b1, "R11", {31'h0, done}, 32'h1);
    nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    n = 0; ea = a; seq_ok = 1;
    for (int rem = nb; rem > 0; rem -= w) begin
      w = (mode == 2 || ea[0] || rem == 1) ? 1 : 2;
      if (n < 8 && (log_addr[n] !== 16'(ea) ||
          log_be[n] !== ((mode == 2) ? 2'b01 : (w == 2) ? 2'b11 : (ea[0] ? 2'b10 : 2'b01))))
        seq_ok = 0;
      ea += w; n++;
    end
    if (mode == 2) tag = "R2";
    else if (sz == 1 && a[0]) tag = "R4";
    else if (sz == 2 && a[0]) tag = "R5";
    else if (sz == 2 && a[1:0] == 2'b10) tag = "R6";
    else tag = "R3";
    if (mode == 0) tag = {tag, " R12"};
    check(seq_ok && log_n == n, {tag, " R7 sequence"}, 32'(log_n), 32'(n));
    if (wr) begin
      bit m_ok = 1;
      for (int k = 0; k < nb; k++) shadow[a + k] = wd[8*k +: 8];
      for (int i = 0; i < 64; i++) if (mem[i] !== shadow[i]) m_ok = 0;
      check(m_ok, "R8 memory image", {24'h0, mem[a]}, {24'h0, shadow[a]});
      if (mode != 2) check(rep_ok, "R7 byte replication", 32'(rep_ok), 32'h1);
    end else begin
      exp_rd = 0;
      for (int k = 0; k < nb; k++) exp_rd[8*k +: 8] = mem[a + k];
      check(rdata === exp_rd, "R9 read merge", rdata, exp_rd);
    end
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R11 single pulse", {30'h0, done, busy}, 32'h0);
    if (!wr) check(rdata === exp_rd, "R11 rdata held", rdata, exp_rd);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busy === 0 && bus_valid === 0 && done === 0 && rdata === 32'h0,
          "R1 reset state", {rdata[27:0], busy, bus_valid, done, 1'b0}, 32'h0);

    for (int mode = 0; mode < 3; mode++)
      for (int sz = 0; sz < 3; sz++)
        for (int off = 0; off < 4; off++)
          for (int wr = 0; wr < 2; wr++) begin
            stall_en = ((mode + sz + off) % 2) == 1;
            access(wr[0], sz[1:0], 8'(16 + 8 * sz + off), mode,
                   32'h1000_0000 * (mode + 1) + 32'h0102_0304 * (off + 3) + 32'(sz));
          end

    begin
      logic [15:0] held;
      logic [7:0] keep [0:3];
      for (int k = 0; k < 4; k++) keep[k] = mem[44 + k];
      stall_en = 0; force_stall = 1; narrow_bus = 0; log_n = 0;
      @(negedge clk);
      req_valid = 1; req_write = 1; req_size = 2'b10; req_addr = 16'd5;
      req_wdata = 32'hA1B2C3D4; req_periph = 0; cfg_ext8 = 0;
      @(negedge clk);
      req_addr = 16'd44; req_wdata = 32'h5A5A5A5A;
      held = bus_addr;
      @(negedge clk);
      check(busy === 1'b1 && bus_addr === held && held === 16'd5, "R10 stall hold",
            {16'h0, bus_addr}, 32'd5);
      @(negedge clk);
      req_valid = 0; force_stall = 0;
      wait_done();
      check(log_n == 3 && log_addr[0] === 16'd5 && mem[44] === keep[0] && mem[47] === keep[3],
            "R1 busy ignores request", 32'(log_n), 32'd3);
      check(mem[5] === 8'hD4 && mem[6] === 8'hC3 && mem[7] === 8'hB2 && mem[8] === 8'hA1,
            "R8 R5 odd word write", {mem[8], mem[7], mem[6], mem[5]}, 32'hA1B2C3D4);
    end

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule